// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block chooses a sampling clock tap for a high-speed card interface once a tuning sweep has finished. The sweep visits every one of N delay taps twice, so each of its two result masks carries 2×N probe bits, and probe i belongs to tap i mod N. One mask marks the probes whose tuning command came back without error. The other marks the probes whose sampled data compared cleanly. A tap only counts as good when both of its probes are good.

After a start strobe the block works through the latched masks one bit per clock. It folds the two sweeps together, looks for the longest unbroken run of good probes and takes the centre of that run, wrapped back into the range 0..N-1, as the new tap. When every command probe passed, the command mask gives no information, so the block repeats the run search on the data-compare mask. Otherwise it requires a minimum run length. A successful search updates the tap output and pulses an enable for automatic re-tuning. A failed search raises an error and leaves the previous tap in place.

Top module: `tap_window_selector`

## Requirements
- R1: For each mask, probe bits t and t+N are both kept only if both are 1; if either is 0, both are treated as 0. Mask bits at positions 2×N and above have no effect on the result.
- R2: The search scans the folded command mask from bit 0 up to bit 2×N-1. A run that is still open at the top bit counts, so a mask that is entirely ones forms a single run of length 2×N.
- R3: If several runs share the greatest length, the one that starts lowest is chosen.
- R4: If the longest command run is shorter than 2×N, the result is accepted only when its length is at least MIN_RUN (default 3). The tap is then ((first + last) / 2) mod N, with integer division.
- R5: If the longest command run covers all 2×N bits, the run search is repeated on the folded compare mask. The result is accepted when that run is at least one bit long, and its tap uses the same centre-and-wrap rule.
- R6: A rejected result pulses `error` together with `done`. `tap_sel` keeps its previous value and `retune_en` stays low.
- R7: An accepted result loads the new tap into `tap_sel` on the same edge that raises `done`. `retune_en` is high for exactly that one cycle and `error` stays low.
- R8: If `start` is seen with `tap_count` equal to 0 or greater than MAX_TAPS, `done` and `error` are high in the very next cycle and `tap_sel` does not change.
- R9: Each accepted start gives exactly one `done` pulse, one cycle long. A `start` that arrives while a search is running is ignored. The inputs are latched when the search starts.
- R10: After reset, `tap_sel` is 0 and `done`, `error` and `retune_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a search; sampled only while idle |
| tap_count | input | 5 | Number of taps N, valid range 1..MAX_TAPS |
| pass_mask | input | 16 | Command-status probe results, bit i for probe i |
| cmp_mask | input | 16 | Data-compare probe results, bit i for probe i |
| tap_sel | output | 3 | Selected sampling tap; held between accepted results |
| done | output | 1 | One-cycle pulse when a search ends |
| error | output | 1 | High with done when no window was accepted |
| retune_en | output | 1 | High with done when a new tap was accepted |

## Verification
The hardest path to reach is the fallback to the compare mask. It needs every command probe to survive the fold, so the command run must stay open all the way to the top bit. The stimulus drives an all-ones command mask with several compare patterns: a single good tap, a run that straddles the two sweeps, and an all-zero mask that must be rejected. One of these cases also puts ones above bit 2×N-1 with an odd tap count. Runs that cross the seam between the two sweeps show the wrap of the centre index. Equal-length runs in both halves show that the lowest run wins.

// File: rtl/tap_sel_pkg.sv
// Package: shared state encoding for the tap window selector.
// Assumes: one controller instance owns the state; no other consumers.
package tap_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MERGE,
        ST_SCAN_P,
        ST_JUDGE_P,
        ST_SCAN_C,
        ST_JUDGE_C
    } sel_state_e;

endpackage

// File: rtl/tsel_merge_step.sv
// Module: one fold step of a double-sweep mask.
// Does:   if probe bit idx is 0, clears the two bits of the same tap
//         (idx mod n and idx mod n + n).
// Assumes: 1 <= n and idx < 2*n <= MASK_W; purely combinational.
module tsel_merge_step #(
    parameter int MASK_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic [MASK_W-1:0] mask_in,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  n,
    output logic [MASK_W-1:0] mask_out
);
    localparam logic [MASK_W-1:0] ONE = MASK_W'(1);

    logic [IDX_W-1:0]  low;
    logic [MASK_W-1:0] shifted;

    // Fold the probe index back onto its tap and clear both copies if the probe failed.
    always_comb begin
        low      = (idx >= n) ? (idx - n) : idx;
        shifted  = mask_in >> idx;
        mask_out = mask_in;
        if (!shifted[0]) begin
            mask_out = mask_in & ~(ONE << low) & ~(ONE << (low + n));
        end
    end
endmodule

// File: rtl/tsel_run_tracker.sv
// Module: longest-run tracker fed one bit per clock.
// Does:   counts consecutive ones and keeps the first strictly longest run
//         (length, first index, last index). A zero bit closes a run.
// Assumes: the caller feeds a trailing zero after the last real bit so an
//          open run at the top gets closed; clr restarts all tracking.
module tsel_run_tracker #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             bit_in,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] best_len,
    output logic [IDX_W-1:0] best_first,
    output logic [IDX_W-1:0] best_last
);
    logic [IDX_W-1:0] run_len;

    // Extend the open run or close it and keep it if strictly longer than the best.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_len    <= '0;
            best_len   <= '0;
            best_first <= '0;
            best_last  <= '0;
        end else if (step) begin
            if (bit_in) begin
                run_len <= run_len + 1'b1;
            end else begin
                if (run_len > best_len) begin
                    best_len   <= run_len;
                    best_first <= idx - run_len;
                    best_last  <= idx - 1'b1;
                end
                run_len <= '0;
            end
        end
    end
endmodule

// File: rtl/tsel_center.sv
// Module: centre-of-window tap calculation.
// Does:   tap = ((first + last) / 2) mod n.
// Assumes: first <= last < 2*n, so a single conditional subtract wraps it.
module tsel_center #(
    parameter int IDX_W = 5,
    parameter int TAP_W = 3
) (
    input  logic [IDX_W-1:0] first,
    input  logic [IDX_W-1:0] last,
    input  logic [IDX_W-1:0] n,
    output logic [TAP_W-1:0] tap
);
    logic [IDX_W-1:0] mid;

    // Halve the index sum, then wrap the midpoint onto the first sweep.
    always_comb begin
        mid = IDX_W'(({1'b0, first} + {1'b0, last}) >> 1);
        tap = TAP_W'((mid >= n) ? (mid - n) : mid);
    end
endmodule

// File: rtl/tap_window_selector.sv
// Module: sampling tap window selector (top).
// Does:   latches two 2xN probe masks on start, folds each one
//         (one bit/clk), scans the command mask for its longest run
//         (one bit/clk), falls back to scanning the compare mask if every
//         probe passed, then outputs the wrapped centre tap or an error.
// Assumes: tap_count in 1..MAX_TAPS, otherwise it rejects the start at once.
module tap_window_selector #(
    parameter int MAX_TAPS = 8,
    parameter int MIN_RUN  = 3,
    localparam int MASK_W  = 2 * MAX_TAPS,
    localparam int IDX_W   = $clog2(MASK_W + 1),
    localparam int TAP_W   = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  tap_count,
    input  logic [MASK_W-1:0] pass_mask,
    input  logic [MASK_W-1:0] cmp_mask,
    output logic [TAP_W-1:0]  tap_sel,
    output logic              done,
    output logic              error,
    output logic              retune_en
);
    import tap_sel_pkg::*;

    sel_state_e        state;
    logic [MASK_W-1:0] mask_q   [2];
    logic [MASK_W-1:0] merged   [2];
    logic [IDX_W-1:0]  n_q;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  two_n;
    logic [IDX_W-1:0]  best_len;
    logic [IDX_W-1:0]  best_first;
    logic [IDX_W-1:0]  best_last;
    logic [TAP_W-1:0]  center_tap;
    logic [TAP_W-1:0]  tap_q;
    logic              done_q;
    logic              err_q;
    logic              rt_q;
    logic              count_bad;
    logic              merge_last;
    logic              full_pass;
    logic              accept;
    logic              trk_clr;
    logic              trk_step;
    logic              scan_bit;
    logic [MASK_W-1:0] scan_shift;
    logic              busy;

    // One fold unit for each mask: command status and data compare.
    for (genvar g = 0; g < 2; g++) begin : g_merge
        tsel_merge_step #(.MASK_W(MASK_W), .IDX_W(IDX_W)) merge_i (
            .mask_in (mask_q[g]),
            .idx     (idx),
            .n       (n_q),
            .mask_out(merged[g])
        );
    end

    tsel_run_tracker #(.IDX_W(IDX_W)) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (trk_clr),
        .step      (trk_step),
        .bit_in    (scan_bit),
        .idx       (idx),
        .best_len  (best_len),
        .best_first(best_first),
        .best_last (best_last)
    );

    tsel_center #(.IDX_W(IDX_W), .TAP_W(TAP_W)) center_i (
        .first(best_first),
        .last (best_last),
        .n    (n_q),
        .tap  (center_tap)
    );

    // Decode the control conditions used by the state machine and the tracker.
    always_comb begin
        two_n      = IDX_W'(n_q << 1);
        count_bad  = (tap_count == '0) || (tap_count > IDX_W'(MAX_TAPS));
        merge_last = (state == ST_MERGE) && (idx == two_n - 1'b1);
        full_pass  = (best_len == two_n);
        accept     = (state == ST_JUDGE_C) ? (best_len != '0)
                                           : (best_len >= IDX_W'(MIN_RUN));
        trk_clr    = merge_last || ((state == ST_JUDGE_P) && full_pass);
        trk_step   = (state == ST_SCAN_P) || (state == ST_SCAN_C);
        scan_shift = ((state == ST_SCAN_C) ? mask_q[1] : mask_q[0]) >> idx;
        scan_bit   = (idx < two_n) && scan_shift[0];
        busy       = (state != ST_IDLE);
    end

    // Sequence latch, fold, scan and decide; register the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mask_q[0] <= '0;
            mask_q[1] <= '0;
            n_q       <= '0;
            idx       <= '0;
            tap_q     <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rt_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rt_q   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (count_bad) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            mask_q[0] <= pass_mask;
                            mask_q[1] <= cmp_mask;
                            n_q       <= tap_count;
                            idx       <= '0;
                            state     <= ST_MERGE;
                        end
                    end
                end
                ST_MERGE: begin
                    for (int g = 0; g < 2; g++) mask_q[g] <= merged[g];
                    if (merge_last) begin
                        idx   <= '0;
                        state <= ST_SCAN_P;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SCAN_P: begin
                    if (idx == two_n) state <= ST_JUDGE_P;
                    else              idx   <= idx + 1'b1;
                end
                ST_SCAN_C: begin
                    if (idx == two_n) state <= ST_JUDGE_C;
                    else              idx   <= idx + 1'b1;
                end
                ST_JUDGE_P, ST_JUDGE_C: begin
                    if ((state == ST_JUDGE_P) && full_pass) begin
                        idx   <= '0;
                        state <= ST_SCAN_C;
                    end else begin
                        done_q <= 1'b1;
                        err_q  <= !accept;
                        rt_q   <= accept;
                        if (accept) tap_q <= center_tap;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tap_sel   = tap_q;
    assign done      = done_q;
    assign error     = err_q;
    assign retune_en = rt_q;
endmodule

// File: rtl/tsel_checker.sv
// Module: protocol checker for tap_window_selector, bound to every instance.
// Does:   checks pulse shapes, result exclusivity, tap hold and bad-count reject.
// Assumes: sees the top's ports plus its idle/busy indication.
module tsel_checker #(
    parameter int MAX_TAPS = 8,
    parameter int IDX_W    = 5,
    parameter int TAP_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [IDX_W-1:0] tap_count,
    input logic             busy,
    input logic [TAP_W-1:0] tap_sel,
    input logic             done,
    input logic             error,
    input logic             retune_en
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                         // R9
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                         // R9
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);                                         // R6
    AST_ERR_HOLDS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> $stable(tap_sel));                   // R6
    AST_RETUNE_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        retune_en |-> (done && !error));                         // R7
    AST_OK_GIVES_RETUNE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> retune_en);                         // R7
    AST_TAP_MOVES_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_sel) |-> retune_en);                        // R7
    AST_BAD_COUNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((tap_count == '0) || (tap_count > IDX_W'(MAX_TAPS))))
        |=> (done && error));                                    // R8
endmodule

bind tap_window_selector tsel_checker #(
    .MAX_TAPS(MAX_TAPS),
    .IDX_W   (IDX_W),
    .TAP_W   (TAP_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tap_count(tap_count),
    .busy     (busy),
    .tap_sel  (tap_sel),
    .done     (done),
    .error    (error),
    .retune_en(retune_en)
);

// File: tb/tap_window_selector_tb_top.sv
`timescale 1ns/1ps
module tap_window_selector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [4:0]  tap_count;
    logic [15:0] pass_mask;
    logic [15:0] cmp_mask;
    logic [2:0]  tap_sel;
    logic        done;
    logic        error;
    logic        retune_en;

    int n_checks = 0;
    int n_fails  = 0;
    int held_tap = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tap_window_selector dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tap_count(tap_count),
        .pass_mask(pass_mask),
        .cmp_mask (cmp_mask),
        .tap_sel  (tap_sel),
        .done     (done),
        .error    (error),
        .retune_en(retune_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Longest strictly-longer run over bits 0..w-1 (model of R2/R3).
    function automatic void longest(input logic [15:0] m, input int w,
                                    output int len, output int first, output int last);
        int run = 0;
        len = 0; first = 0; last = 0;
        for (int i = 0; i <= w; i++) begin
            if (i < w && m[i]) run++;
            else begin
                if (run > len) begin len = run; first = i - run; last = i - 1; end
                run = 0;
            end
        end
    endfunction

    // Requirement model: fold (R1), search (R2..R5), centre wrap (R4).
    function automatic void model(input int n, input logic [15:0] p, input logic [15:0] c,
                                  output bit ok, output int tap);
        logic [15:0] mp = '0;
        logic [15:0] mc = '0;
        int len, f, l;
        ok = 1'b0; tap = 0;
        if (n == 0 || n > 8) return;
        for (int j = 0; j < 2 * n; j++) begin
            mp[j] = p[j % n] & p[(j % n) + n];
            mc[j] = c[j % n] & c[(j % n) + n];
        end
        longest(mp, 2 * n, len, f, l);
        if (len == 2 * n) begin
            longest(mc, 2 * n, len, f, l);
            ok = (len != 0);
        end else begin
            ok = (len >= 3);
        end
        tap = ((f + l) / 2) % n;
    endfunction

    // Drive one search and check done/error/retune/tap against the model.
    task automatic run_case(input string req, input int n, input logic [15:0] p,
                            input logic [15:0] c, input int max_wait);
        bit ok; int tap; int cyc = 0;
        model(n, p, c, ok, tap);
        @(negedge clk);
        tap_count = 5'(n); pass_mask = p; cmp_mask = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 500) begin @(negedge clk); cyc++; end
        check(done == 1'b1, req, "done seen", int'(done), 1);
        check(cyc <= max_wait, req, "latency", cyc, max_wait);
        check(error == !ok, req, "error", int'(error), int'(!ok));
        check(retune_en == ok, req, "retune_en", int'(retune_en), int'(ok));
        if (ok) held_tap = tap;
        check(int'(tap_sel) == held_tap, req, "tap_sel", int'(tap_sel), held_tap);
        @(negedge clk);
        check(done == 1'b0, req, "done one cycle", int'(done), 0);
    endtask

    // R9: a second start during a search is ignored; inputs are latched.
    task automatic busy_start_case();
        int dones = 0;
        @(negedge clk);
        tap_count = 5'd8; pass_mask = 16'h3C3C; cmp_mask = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        pass_mask = 16'hFFFF; tap_count = 5'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 120; k++) begin
            if (done) begin
                dones++;
                check(error == 1'b0, "R9", "busy start error", int'(error), 0);
                check(tap_sel == 3'd3, "R9", "busy start tap", int'(tap_sel), 3);
            end
            @(negedge clk);
        end
        held_tap = 3;
        check(dones == 1, "R9", "done count", dones, 1);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; tap_count = '0; pass_mask = '0; cmp_mask = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        check(tap_sel == 3'd0, "R10", "reset tap_sel", int'(tap_sel), 0);
        check(done == 1'b0 && error == 1'b0 && retune_en == 1'b0, "R10",
              "reset flags", int'({done, error, retune_en}), 0);

        // R3/R4: taps 2..5 good in both sweeps; equal runs, lower wins -> tap 3
        run_case("R3", 8, 16'h3C3C, 16'h0000, 80);
        // R1: tap 4 fails only in second sweep -> bits 4,12 both cleared -> tap 0
        run_case("R1", 8, 16'hEFFF, 16'h0000, 80);
        // R4: run of length 2 rejected; tap held at 0
        run_case("R4", 8, 16'h1818, 16'h0000, 80);
        // R4: exactly three taps 3..5 -> tap 4
        run_case("R4", 8, 16'h3838, 16'h0000, 80);
        // R4: run crossing the sweep seam (taps 6,7,0,1) -> centre 7
        run_case("R4", 8, 16'hC3C3, 16'h0000, 80);
        // R4: N=4 taps 3,0,1 -> run 3..5 -> centre 4 wraps to 0
        run_case("R4", 4, 16'h00BB, 16'h0000, 80);
        // R2/R5: all probes pass, compare good only on tap 6 -> tap 6
        run_case("R5", 8, 16'hFFFF, 16'h4040, 80);
        // R2/R5: all pass, compare seam run taps 7,0 -> centre 7
        run_case("R5", 8, 16'hFFFF, 16'h8181, 80);
        // R1/R5: N=5 with junk above bit 9; compare taps 1..3 -> tap 2
        run_case("R1", 5, 16'hFFFF, 16'hFDCE, 80);
        // R5/R6: all pass, compare all zero -> rejected, tap held
        run_case("R6", 8, 16'hFFFF, 16'h0000, 80);
        // R8: N=0 and N=9 rejected on the next cycle
        run_case("R8", 0, 16'hFFFF, 16'hFFFF, 1);
        run_case("R8", 9, 16'hFFFF, 16'hFFFF, 1);
        // R7: accepted result after rejections updates tap (N=3, taps 0..2 pass, cmp tap 1)
        run_case("R7", 3, 16'h003F, 16'h0012, 80);
        busy_start_case();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule